// File: doc/BRIEF.md
# Inter-Core Interrupt Signalling Unit

This block lets any one of `NCORE` cores raise an interrupt on another core. The receiving core can then find out which cores signalled it and clear each of them. Every core has its own command port, made of a strobe, a two-bit operation code and a core index, and its own readback register. The operations are: raise an interrupt on a target, peek whether a target already has something pending, ask which senders are pending against the caller, and clear one sender's request.

Internally the unit keeps an `NCORE` x `NCORE` matrix of pending flags. There is one flag for each (receiver, sender) pair. A core's interrupt line is the OR of its receiver row. Several senders that hit the same target therefore merge onto a single asserted line, and the receiver tells them apart through the sender bitmask. Commands from different cores in the same cycle are all applied. The commands need no arbitration because each core has a private port.

Top module: `icsu_top`

## Requirements
- R1: After a synchronous active-high reset, every pending flag is clear, every `irq` bit is 0 and every readback register reads 0.
- R2: A raise command (op `2'b00`) from core S with index T, where T differs from S, sets the (T, S) flag. `irq[T]` is 1 from the clock edge that takes the command.
- R3: A raise command whose index equals the issuing core changes no flag and no `irq` bit.
- R4: A peek command (op `2'b01`) from core C with index T loads C's readback with bit 0 equal to 1 if any flag in T's row is set and all other bits 0. It reflects the state before any command taken at the same edge.
- R5: A who command (op `2'b10`) from core C loads C's readback with C's row. Bit S is 1 when sender S has a pending request to C, so the values are 1, 2, 4 and 8 for cores 0 to 3.
- R6: Raise commands from several cores to one target at the same edge set all their flags. The target sees a single asserted line, and its who result has several bits set.
- R7: A clear command (op `2'b11`) from core C with index S clears only the (C, S) flag.
- R8: `irq[C]` stays 1 until every flag in C's row has been cleared. It then drops at the edge that takes the last clear.
- R9: If a raise from S to T and a clear by T of sender S are taken at the same edge, the (T, S) flag stays set.
- R10: Each core's readback changes only at an edge that takes a command from that core, and holds otherwise. Raise and clear commands load it with 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | NCORE | Per-core command strobe |
| cmd_op | input | 2*NCORE | Per-core operation code, core c at bits [2c+1:2c] |
| cmd_idx | input | IDXW*NCORE | Per-core target or sender index, core c at bits [IDXW*c +: IDXW] |
| rdback | output | NCORE*NCORE | Per-core readback register, core c at bits [NCORE*c +: NCORE] |
| irq | output | NCORE | Per-core interrupt line |

## Verification
The bench issues raises from three cores to one target at the same edge. A design that kept one sender per target would lose requests, and its who result would show a single bit. It clears one sender of a merged row and checks that the line stays high and the other bits survive. A design that cleared the whole row, or dropped the line early, fails that check. It puts a raise and a clear for one pair on the same edge, where a design in which the clear wins would lose the new event. It also issues a peek alongside a raise to the peeked target, and a self-targeted raise. In a wrong design the peek would report the new state and the self-targeted raise would interrupt its own sender.

// File: rtl/icsu_pkg.sv
package icsu_pkg;

    // Operation codes carried on each core's command port
    typedef enum logic [1:0] {
        OP_RAISE = 2'b00,
        OP_PEEK  = 2'b01,
        OP_WHO   = 2'b10,
        OP_CLEAR = 2'b11
    } icsu_op_e;

    // Decoded form of one command
    typedef struct packed {
        logic raise;
        logic peek;
        logic who;
        logic clear;
    } icsu_dec_t;

    function automatic icsu_dec_t decode_op(input logic vld, input icsu_op_e op);
        icsu_dec_t d;
        d.raise = vld && (op == OP_RAISE);
        d.peek  = vld && (op == OP_PEEK);
        d.who   = vld && (op == OP_WHO);
        d.clear = vld && (op == OP_CLEAR);
        return d;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/icsu_cmd_dec.sv
module icsu_cmd_dec
    import icsu_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int SELF  = 0,
    localparam int IDXW = idx_width(NCORE)
) (
    input  logic             vld,
    input  logic [1:0]       op,
    input  logic [IDXW-1:0]  idx,
    output icsu_dec_t        dec,
    output logic [NCORE-1:0] idx_oh,
    output logic [NCORE-1:0] raise_oh,
    output logic [NCORE-1:0] clear_oh
);
    localparam logic [NCORE-1:0] SELF_BIT = NCORE'(1) << SELF;

    assign dec = decode_op(vld, icsu_op_e'(op));

    // Full index decode; an index beyond NCORE-1 decodes to all zeros
    for (genvar t = 0; t < NCORE; t++) begin : g_oh
        assign idx_oh[t] = (idx == IDXW'(t));
    end

    // A raise never lands on the issuing core itself
    assign raise_oh = dec.raise ? (idx_oh & ~SELF_BIT) : '0;
    assign clear_oh = dec.clear ? idx_oh : '0;
endmodule

// File: rtl/icsu_pend_mtx.sv
module icsu_pend_mtx #(
    parameter int NCORE = 4,
    localparam int NBIT = NCORE * NCORE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBIT-1:0]  set_m,   // row r = receiver, column s = sender
    input  logic [NBIT-1:0]  clr_m,
    output logic [NBIT-1:0]  pend,
    output logic [NCORE-1:0] row_any
);
    for (genvar b = 0; b < NBIT; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend[b] <= 1'b0;
            else if (set_m[b])
                pend[b] <= 1'b1;      // a new event beats a clear
            else if (clr_m[b])
                pend[b] <= 1'b0;
        end
    end

    for (genvar r = 0; r < NCORE; r++) begin : g_row
        assign row_any[r] = |pend[r*NCORE +: NCORE];
    end
endmodule

// File: rtl/icsu_rdbk.sv
module icsu_rdbk
    import icsu_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  icsu_dec_t        dec,
    input  logic [NCORE-1:0] idx_oh,
    input  logic [NCORE-1:0] own_row,
    input  logic [NCORE-1:0] row_any,
    output logic [NCORE-1:0] rdata
);
    logic             peek_hit;
    logic [NCORE-1:0] rnext;

    assign peek_hit = |(row_any & idx_oh);

    always_comb begin
        rnext = '0;
        if (dec.peek)
            rnext = NCORE'(peek_hit);
        else if (dec.who)
            rnext = own_row;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (vld)
            rdata <= rnext;
    end
endmodule

// File: rtl/icsu_top.sv
module icsu_top
    import icsu_pkg::*;
#(
    parameter int NCORE = 4,
    localparam int IDXW = idx_width(NCORE)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCORE-1:0]        cmd_vld,
    input  logic [2*NCORE-1:0]      cmd_op,
    input  logic [IDXW*NCORE-1:0]   cmd_idx,
    output logic [NCORE*NCORE-1:0]  rdback,
    output logic [NCORE-1:0]        irq
);
    localparam int NBIT = NCORE * NCORE;

    icsu_dec_t        dec      [NCORE];
    logic [NCORE-1:0] idx_oh   [NCORE];
    logic [NCORE-1:0] raise_oh [NCORE];
    logic [NCORE-1:0] clear_oh [NCORE];
    logic [NBIT-1:0]  set_m;
    logic [NBIT-1:0]  clr_m;
    logic [NBIT-1:0]  pend;
    logic [NCORE-1:0] row_any;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        icsu_cmd_dec #(.NCORE(NCORE), .SELF(c)) u_dec (
            .vld      (cmd_vld[c]),
            .op       (cmd_op[2*c +: 2]),
            .idx      (cmd_idx[IDXW*c +: IDXW]),
            .dec      (dec[c]),
            .idx_oh   (idx_oh[c]),
            .raise_oh (raise_oh[c]),
            .clear_oh (clear_oh[c])
        );

        icsu_rdbk #(.NCORE(NCORE)) u_rdbk (
            .clk     (clk),
            .rst     (rst),
            .vld     (cmd_vld[c]),
            .dec     (dec[c]),
            .idx_oh  (idx_oh[c]),
            .own_row (pend[c*NCORE +: NCORE]),
            .row_any (row_any),
            .rdata   (rdback[c*NCORE +: NCORE])
        );
    end

    // Sender s raising target r sets bit (r, s); receiver r clearing s clears it
    for (genvar r = 0; r < NCORE; r++) begin : g_r
        for (genvar s = 0; s < NCORE; s++) begin : g_s
            assign set_m[r*NCORE + s] = raise_oh[s][r];
            assign clr_m[r*NCORE + s] = clear_oh[r][s];
        end
    end

    icsu_pend_mtx #(.NCORE(NCORE)) u_mtx (
        .clk     (clk),
        .rst     (rst),
        .set_m   (set_m),
        .clr_m   (clr_m),
        .pend    (pend),
        .row_any (row_any)
    );

    assign irq = row_any;
endmodule

// File: rtl/icsu_checker.sv
module icsu_checker
    import icsu_pkg::*;
#(
    parameter int NCORE = 4,
    localparam int IDXW = idx_width(NCORE)
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NCORE-1:0]       cmd_vld,
    input logic [2*NCORE-1:0]     cmd_op,
    input logic [IDXW*NCORE-1:0]  cmd_idx,
    input logic [NCORE*NCORE-1:0] rdback,
    input logic [NCORE-1:0]       irq,
    input logic [NCORE*NCORE-1:0] pend
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (irq == '0 && rdback == '0));

    for (genvar c = 0; c < NCORE; c++) begin : g_c
        assert_no_self_flag_R3: assert property (@(posedge clk) disable iff (rst)
            !pend[c*NCORE + c]);

        assert_who_row_R5: assert property (@(posedge clk) disable iff (rst)
            (cmd_vld[c] && cmd_op[2*c +: 2] == OP_WHO)
            |=> rdback[c*NCORE +: NCORE] == $past(pend[c*NCORE +: NCORE]));

        assert_peek_bit_R4: assert property (@(posedge clk) disable iff (rst)
            (cmd_vld[c] && cmd_op[2*c +: 2] == OP_PEEK)
            |=> rdback[c*NCORE] == $past(|pend[NCORE*cmd_idx[IDXW*c +: IDXW] +: NCORE]));

        assert_hold_rdbk_R10: assert property (@(posedge clk) disable iff (rst)
            !cmd_vld[c] |=> $stable(rdback[c*NCORE +: NCORE]));

        assert_drop_needs_clear_R8: assert property (@(posedge clk) disable iff (rst)
            $fell(irq[c]) |-> $past(cmd_vld[c] && cmd_op[2*c +: 2] == OP_CLEAR));

        for (genvar s = 0; s < NCORE; s++) begin : g_s
            if (s != c) begin : g_pair
                // raise from s to c; also covers the R9 race since a clear cannot veto it
                assert_raise_sets_R2: assert property (@(posedge clk) disable iff (rst)
                    (cmd_vld[s] && cmd_op[2*s +: 2] == OP_RAISE
                     && cmd_idx[IDXW*s +: IDXW] == IDXW'(c))
                    |=> (pend[c*NCORE + s] && irq[c]));

                assert_clear_pair_R7: assert property (@(posedge clk) disable iff (rst)
                    (cmd_vld[c] && cmd_op[2*c +: 2] == OP_CLEAR
                     && cmd_idx[IDXW*c +: IDXW] == IDXW'(s)
                     && !(cmd_vld[s] && cmd_op[2*s +: 2] == OP_RAISE
                          && cmd_idx[IDXW*s +: IDXW] == IDXW'(c)))
                    |=> !pend[c*NCORE + s]);
            end
        end
    end
endmodule

bind icsu_top icsu_checker #(.NCORE(NCORE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cmd_vld (cmd_vld),
    .cmd_op  (cmd_op),
    .cmd_idx (cmd_idx),
    .rdback  (rdback),
    .irq     (irq),
    .pend    (pend)
);

// File: tb/icsu_top_test.sv
module icsu_top_test;
    localparam int NC = 4;
    localparam int IW = 2;
    localparam logic [1:0] RAISE = 2'b00, PEEK = 2'b01, WHO = 2'b10, CLEAR = 2'b11;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NC-1:0]     cmd_vld = '0;
    logic [2*NC-1:0]   cmd_op = '0;
    logic [IW*NC-1:0]  cmd_idx = '0;
    logic [NC*NC-1:0]  rdback;
    logic [NC-1:0]     irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    icsu_top #(.NCORE(NC)) uut (
        .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .rdback(rdback), .irq(irq)
    );

    task automatic put(input int c, input logic [1:0] op, input int idx);
        cmd_vld[c]           = 1'b1;
        cmd_op[2*c +: 2]     = op;
        cmd_idx[IW*c +: IW]  = IW'(idx);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cmd_vld = '0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] rb(input int c);
        return rdback[c*NC +: NC];
    endfunction

    task automatic t_reset();
        chk("R1 irq after reset", 32'(irq), 0);
        chk("R1 rdback after reset", 32'(rdback), 0);
    endtask

    task automatic t_single();
        put(0, RAISE, 2); step();
        chk("R2 irq after raise 0->2", 32'(irq), 32'h4);
        put(2, WHO, 0); put(1, PEEK, 2); put(3, PEEK, 3); step();
        chk("R5 who of core2", 32'(rb(2)), 32'h1);
        chk("R4 peek of busy core2", 32'(rb(1)), 32'h1);
        chk("R4 peek of idle core3", 32'(rb(3)), 32'h0);
        put(2, CLEAR, 0); step();
        chk("R8 irq after only clear", 32'(irq), 32'h0);
    endtask

    task automatic t_self();
        put(1, RAISE, 1); step();
        chk("R3 irq after self raise", 32'(irq), 32'h0);
        put(1, WHO, 0); step();
        chk("R3 who after self raise", 32'(rb(1)), 32'h0);
    endtask

    task automatic t_merge();
        put(0, RAISE, 2); put(1, RAISE, 2); put(3, RAISE, 2); step();
        chk("R6 single line for three senders", 32'(irq), 32'h4);
        put(2, WHO, 0); step();
        chk("R6 who shows three senders", 32'(rb(2)), 32'hB);
        put(2, CLEAR, 1); step();
        chk("R8 line held after partial clear", 32'(irq), 32'h4);
        put(2, WHO, 0); step();
        chk("R7 only sender1 cleared", 32'(rb(2)), 32'h9);
        put(2, CLEAR, 0); step();
        chk("R8 line held with one left", 32'(irq), 32'h4);
        put(2, CLEAR, 3); step();
        chk("R8 line drops after last clear", 32'(irq), 32'h0);
    endtask

    task automatic t_race();
        put(3, RAISE, 0); step();
        put(3, RAISE, 0); put(0, CLEAR, 3); step();
        chk("R9 raise beats clear on irq", 32'(irq), 32'h1);
        put(0, WHO, 0); step();
        chk("R9 raise beats clear on who", 32'(rb(0)), 32'h8);
        put(0, CLEAR, 3); step();
        chk("R7 clear after race", 32'(irq), 32'h0);
    endtask

    task automatic t_hold();
        put(0, RAISE, 1); put(2, PEEK, 1); step();
        chk("R4 peek sees state before same-edge raise", 32'(rb(2)), 32'h0);
        put(2, PEEK, 1); put(3, RAISE, 1); step();
        put(1, WHO, 0); step();
        chk("R5 who of core1", 32'(rb(1)), 32'h9);
        put(0, CLEAR, 1); step();
        repeat (3) step();
        chk("R10 readback holds while idle", 32'(rb(1)), 32'h9);
        chk("R10 peek result kept", 32'(rb(2)), 32'h1);
        put(1, RAISE, 2); step();
        chk("R10 raise loads zero", 32'(rb(1)), 32'h0);
        chk("R2 irq core1 and core2", 32'(irq), 32'h6);
        put(1, CLEAR, 0); put(2, CLEAR, 1); step();
        chk("R7 clear loads zero readback", 32'(rb(2)), 32'h0);
        chk("R8 core1 still has sender3", 32'(irq), 32'h2);
        put(1, CLEAR, 3); step();
        chk("R8 all lines low", 32'(irq), 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_self();
        t_merge();
        t_race();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule